// File: doc/BRIEF.md
# Double-Buffered 16x16 Crosspoint Switch Core

This block is a non-blocking crosspoint that connects sixteen single-bit data inputs to sixteen single-bit data outputs. Every output has its own 16:1 selector. The selector is steered by a 4-bit source code held in an active register bank. As a result, one input can feed any number of outputs at the same time. The path from inputs to outputs is purely combinational.

Reprogramming is double-buffered. Software first places source/destination pairs, one at a time, into a staging bank. A falling edge of the load strobe captures each pair. A falling edge of the active-low configure strobe then copies the whole staging bank into the active bank in a single clock. An override reset holds every output on input 0 and leaves the staging bank untouched, so one configure pulse after the override brings the user mapping back.

A power-on reset initialises both banks so that every output is connected to input 0. All state is synchronous to one clock. Both strobes are sampled on that clock, and their edges are found inside the block.

Top module: `xpoint_core`

## Requirements
- R1: Each output `dout[o]` equals `din[s]`, where `s` is the active source code for output `o`. Several outputs may share one source.
- R2: When `ld_mode` is 0, one clock edge writes `src_addr` into the staging entry numbered `dst_addr`. That edge is the first one at which `load` is sampled 0 after it was sampled 1. The address pins are sampled at that same edge.
- R3: A staging write does not change the outputs by itself. The active bank takes the staging contents at the first edge where `cfg_n` is sampled 0 after being sampled 1. Holding `cfg_n` low does not apply a second time.
- R4: When `ld_mode` is 1 at the load falling edge, the pair is dropped and the staging bank keeps its contents.
- R5: While `rst_n` is low, the active bank is cleared so every output shows `din[0]`. After `rst_n` rises, the outputs stay on input 0 until a configure edge.
- R6: `rst_n` never clears the staging bank, and loads during it are still taken. A configure edge after the override restores the staged mapping.
- R7: A configure edge does not disturb any output whose source code is the same in the staging and active banks.
- R8: While `por_n` is low, both banks are cleared to source 0 and the strobe edge detectors are returned to idle.
- R9: If a load falling edge and a configure falling edge fall on the same clock, the configure applies the staging bank as it stood before that load. The new pair takes effect at the next configure.
- R10: A configure edge while `rst_n` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Synchronous active-low power-on reset; clears both banks |
| rst_n | input | 1 | Synchronous active-low override; forces outputs to input 0, keeps staging |
| ld_mode | input | 1 | 0 = port-by-port loads accepted; 1 = load strobe ignored |
| load | input | 1 | Load strobe; pair captured on its falling edge |
| src_addr | input | 4 | Source input number to connect |
| dst_addr | input | 4 | Destination output number to program |
| cfg_n | input | 1 | Active-low configure strobe; staging copied to active on its falling edge |
| din | input | 16 | Data inputs |
| dout | output | 16 | Data outputs |

## Verification
The bench targets four corner cases.

- A configure pulse held low while a new load arrives. A level-sensitive apply would leak that load onto the outputs.
- A load and a configure that fall on the same clock. A design that forwarded the new pair would move that output one configure too early.
- Configure pulses issued during the override, and the release of the override. A design that cleared the staging bank, or that honoured a configure under reset, would come back on the wrong inputs.
- Loads with the mode select high. A design that took them would silently reroute an output.

// File: rtl/xpoint_pkg.sv
// Package: shared constants for the crosspoint core.
// Assumes: port count is a power of two so the select width covers it exactly.
package xpoint_pkg;
    localparam int unsigned XP_PORTS_DEFAULT = 16;
    // Idle level of each strobe, used to seed its edge detector.
    localparam logic XP_LOAD_IDLE = 1'b0;
    localparam logic XP_CFG_IDLE  = 1'b1;
endpackage

// File: rtl/xpoint_fall_det.sv
// Module: falling-edge finder for a sampled strobe.
// Assumes: strobe is already synchronous to clk; idle level given by parameter.
module xpoint_fall_det #(
    parameter logic IDLE = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic strobe,
    output logic fall
);
    logic prev_q;

    // Remember last sampled level; return to idle on power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) prev_q <= IDLE;
        else        prev_q <= strobe;
    end

    // High for the one cycle where strobe is first seen low after high.
    assign fall = prev_q & ~strobe;
endmodule

// File: rtl/xpoint_regbank.sv
// Module: staging and active selection registers, one pair per output.
// Assumes: wr_en and apply are single-cycle pulses; override has priority over apply.
module xpoint_regbank #(
    parameter int unsigned N_PORTS = 16,
    parameter int unsigned SEL_W   = 4,
    localparam int unsigned FLAT_W = N_PORTS * SEL_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              apply,
    output logic [FLAT_W-1:0] stage_flat,
    output logic [FLAT_W-1:0] active_flat
);
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        logic [SEL_W-1:0] stage_q;
        logic [SEL_W-1:0] active_q;

        // Staging entry: written by an addressed load, cleared only at power-on.
        always_ff @(posedge clk) begin
            if (!por_n)                                stage_q <= '0;
            else if (wr_en && (wr_idx == SEL_W'(p)))   stage_q <= wr_sel;
        end

        // Active entry: forced to input 0 by either reset, else copied on apply.
        always_ff @(posedge clk) begin
            if (!por_n || !rst_n) active_q <= '0;
            else if (apply)       active_q <= stage_q;
        end

        assign stage_flat[p*SEL_W +: SEL_W]  = stage_q;
        assign active_flat[p*SEL_W +: SEL_W] = active_q;
    end
endmodule

// File: rtl/xpoint_selector.sv
// Module: bank of independent N:1 selectors, one per output.
// Assumes: every select code is below N_PORTS.
module xpoint_selector #(
    parameter int unsigned N_PORTS = 16,
    parameter int unsigned SEL_W   = 4,
    localparam int unsigned FLAT_W = N_PORTS * SEL_W
) (
    input  logic [N_PORTS-1:0] din,
    input  logic [FLAT_W-1:0]  sel_flat,
    output logic [N_PORTS-1:0] dout
);
    for (genvar o = 0; o < N_PORTS; o++) begin : g_out
        // Route the selected input bit to this output.
        assign dout[o] = din[sel_flat[o*SEL_W +: SEL_W]];
    end
endmodule

// File: rtl/xpoint_core.sv
// Module: double-buffered non-blocking crosspoint (top).
// Assumes: all inputs synchronous to clk; data path is combinational from the active bank.
module xpoint_core
    import xpoint_pkg::*;
#(
    parameter int unsigned N_PORTS = XP_PORTS_DEFAULT,
    localparam int unsigned SEL_W  = $clog2(N_PORTS),
    localparam int unsigned FLAT_W = N_PORTS * SEL_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic               ld_mode,
    input  logic               load,
    input  logic [SEL_W-1:0]   src_addr,
    input  logic [SEL_W-1:0]   dst_addr,
    input  logic               cfg_n,
    input  logic [N_PORTS-1:0] din,
    output logic [N_PORTS-1:0] dout
);
    logic              load_fall;
    logic              cfg_fall;
    logic              stage_wr;
    logic [FLAT_W-1:0] stage_flat;
    logic [FLAT_W-1:0] active_flat;

    xpoint_fall_det #(.IDLE(XP_LOAD_IDLE)) u_load_edge (
        .clk(clk), .por_n(por_n), .strobe(load), .fall(load_fall)
    );

    xpoint_fall_det #(.IDLE(XP_CFG_IDLE)) u_cfg_edge (
        .clk(clk), .por_n(por_n), .strobe(cfg_n), .fall(cfg_fall)
    );

    // Port-by-port writes are accepted only with the mode select low.
    assign stage_wr = load_fall & ~ld_mode;

    xpoint_regbank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wr_en(stage_wr), .wr_idx(dst_addr), .wr_sel(src_addr),
        .apply(cfg_fall),
        .stage_flat(stage_flat), .active_flat(active_flat)
    );

    xpoint_selector #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_sel (
        .din(din), .sel_flat(active_flat), .dout(dout)
    );
endmodule

// File: rtl/xpoint_core_sva.sv
// Module: property checker for xpoint_core, attached by bind.
// Assumes: sees the top's ports plus both flattened register banks.
module xpoint_core_sva #(
    parameter int unsigned N_PORTS = 16,
    parameter int unsigned SEL_W   = 4,
    localparam int unsigned FLAT_W = N_PORTS * SEL_W
) (
    input logic               clk,
    input logic               por_n,
    input logic               rst_n,
    input logic               ld_mode,
    input logic               load,
    input logic [SEL_W-1:0]   src_addr,
    input logic [SEL_W-1:0]   dst_addr,
    input logic               cfg_n,
    input logic [N_PORTS-1:0] din,
    input logic [N_PORTS-1:0] dout,
    input logic [FLAT_W-1:0]  stage_flat,
    input logic [FLAT_W-1:0]  active_flat
);
    logic ld_seen_q;
    logic cfg_seen_q;
    logic ld_edge;
    logic cfg_edge;

    // Checker-side record of the strobe levels at the previous edge.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            ld_seen_q  <= 1'b0;
            cfg_seen_q <= 1'b1;
        end else begin
            ld_seen_q  <= load;
            cfg_seen_q <= cfg_n;
        end
    end

    assign ld_edge  = ld_seen_q & ~load;
    assign cfg_edge = cfg_seen_q & ~cfg_n;

    function automatic logic [SEL_W-1:0] entry(input logic [FLAT_W-1:0] flat,
                                               input logic [SEL_W-1:0]  idx);
        return flat[idx*SEL_W +: SEL_W];
    endfunction

    // R2: an accepted load lands in the addressed staging entry
    a_r2_stage_write: assert property (@(posedge clk) disable iff (!por_n)
        (ld_edge && !ld_mode) |=> entry(stage_flat, $past(dst_addr)) == $past(src_addr));

    // R4 and R6: without an accepted load the staging bank keeps its value
    a_r4_stage_keep: assert property (@(posedge clk) disable iff (!por_n)
        (ld_mode || !ld_edge) |=> $stable(stage_flat));

    // R3: a configure edge copies the pre-edge staging bank
    a_r3_apply: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && cfg_edge) |=> active_flat == $past(stage_flat));

    // R3: no configure edge, no change to the active bank outside the override
    a_r3_hold: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && !cfg_edge) |=> $stable(active_flat));

    // R5: the override clears the active bank
    a_r5_override: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> active_flat == '0);

    // R5: after an override cycle every output follows input 0
    a_r5_dout: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> dout == {N_PORTS{din[0]}});
endmodule

bind xpoint_core xpoint_core_sva #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_sva (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_mode(ld_mode), .load(load),
    .src_addr(src_addr), .dst_addr(dst_addr), .cfg_n(cfg_n), .din(din), .dout(dout),
    .stage_flat(stage_flat), .active_flat(active_flat)
);

// File: tb/xpoint_core_tb.sv
module xpoint_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        por_n, rst_n, ld_mode, load, cfg_n;
    logic [3:0]  src_addr, dst_addr;
    logic [N-1:0] din, dout;

    int n_chk  = 0;
    int n_fail = 0;
    string cur_req = "R8";

    // Behavioural reference: arrays of selections plus strobe history.
    int m_stage[N];
    int m_act[N];
    bit m_ld_prev, m_cfg_prev;
    // Intended mapping tracked by the test sequence itself.
    int e_stage[N];
    int e_act[N];

    always #(CLK_PERIOD/2) clk = ~clk;

    xpoint_core u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ld_mode(ld_mode), .load(load),
        .src_addr(src_addr), .dst_addr(dst_addr), .cfg_n(cfg_n), .din(din), .dout(dout)
    );

    always @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < N; i++) begin m_stage[i] = 0; m_act[i] = 0; end
            m_ld_prev  = 1'b0;
            m_cfg_prev = 1'b1;
        end else begin
            if (!rst_n)
                for (int i = 0; i < N; i++) m_act[i] = 0;
            else if (m_cfg_prev && !cfg_n)
                for (int i = 0; i < N; i++) m_act[i] = m_stage[i];
            if (m_ld_prev && !load && !ld_mode)
                m_stage[dst_addr] = src_addr;
            m_ld_prev  = load;
            m_cfg_prev = cfg_n;
        end
    end

    function automatic logic [N-1:0] route(input logic [N-1:0] d, input int sel[N]);
        logic [N-1:0] r;
        for (int o = 0; o < N; o++) r[o] = d[sel[o]];
        return r;
    endfunction

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (por_n) begin
            logic [N-1:0] exp_v;
            exp_v = route(din, m_act);
            n_chk++;
            if (dout !== exp_v) begin
                n_fail++;
                $display("FAIL %s cycle compare: dout=%h expected=%h", cur_req, dout, exp_v);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic expect_out(input string req, input logic [N-1:0] exp_v);
        #2;
        n_chk++;
        if (dout !== exp_v) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h", req, dout, exp_v);
        end
    endtask

    task automatic load_pair(input int src, input int dst, input bit mode);
        ld_mode = mode; src_addr = 4'(src); dst_addr = 4'(dst); load = 1'b1;
        tick(1);
        load = 1'b0;
        tick(1);
        ld_mode = 1'b0;
        if (!mode) e_stage[dst] = src;
    endtask

    task automatic configure(input bit honoured);
        cfg_n = 1'b0;
        tick(1);
        cfg_n = 1'b1;
        tick(1);
        if (honoured) for (int i = 0; i < N; i++) e_act[i] = e_stage[i];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, got=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        por_n = 0; rst_n = 1; ld_mode = 0; load = 0; cfg_n = 1;
        src_addr = 0; dst_addr = 0; din = 16'hA5A4;
        for (int i = 0; i < N; i++) begin e_stage[i] = 0; e_act[i] = 0; end
        tick(3);
        por_n = 1;
        tick(1);
        // R8: after power-on every output follows input 0
        expect_out("R8", 16'h0000);
        din = 16'h0001;
        expect_out("R8", 16'hFFFF);

        // R2 / R3: stage a reversed mapping; outputs stay put until configure
        cur_req = "R2";
        for (int o = 0; o < N; o++) load_pair(N - 1 - o, o, 1'b0);
        din = 16'h8000;
        expect_out("R3", 16'h0000);
        cur_req = "R3";
        configure(1'b1);
        for (int i = 0; i < N; i++) begin
            din = 16'(1) << i;
            expect_out("R2", route(din, e_act));
        end

        // R1: one input broadcast to the lower eight outputs
        cur_req = "R1";
        for (int o = 0; o < 8; o++) load_pair(3, o, 1'b0);
        configure(1'b1);
        din = 16'h0008;
        expect_out("R1", 16'h10FF);

        // R3: cfg_n held low does not apply a later load
        cur_req = "R3";
        cfg_n = 1'b0;
        tick(1);
        e_act = e_stage;
        load_pair(6, 9, 1'b0);
        tick(3);
        din = 16'h0040;
        expect_out("R3", route(din, e_act));
        cfg_n = 1'b1;
        tick(1);

        // R4: with the mode select high the load is dropped
        cur_req = "R4";
        load_pair(9, 0, 1'b1);
        configure(1'b1);
        din = 16'h0200;
        expect_out("R4", route(din, e_act));
        din = 16'h0008;
        expect_out("R4", route(din, e_act));

        // R5 / R6 / R10: override, staging survives, configure under override ignored
        cur_req = "R5";
        load_pair(5, 1, 1'b0);
        rst_n = 1'b0;
        tick(3);
        din = 16'hFFFE;
        expect_out("R5", 16'h0000);
        cur_req = "R10";
        configure(1'b0);
        din = 16'h0001;
        expect_out("R10", 16'hFFFF);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) e_act[i] = 0;
        tick(2);
        cur_req = "R5";
        din = 16'h7FFE;
        expect_out("R5", 16'h0000);
        cur_req = "R6";
        configure(1'b1);
        din = 16'h0020;
        expect_out("R6", route(din, e_act));
        din = 16'h1234;
        expect_out("R6", route(din, e_act));

        // R9: load and configure fall together; new pair waits for next configure
        cur_req = "R9";
        src_addr = 4'd11; dst_addr = 4'd2; load = 1'b1;
        tick(1);
        load = 1'b0; cfg_n = 1'b0;
        tick(1);
        cfg_n = 1'b1;
        e_act = e_stage;
        e_stage[2] = 11;
        tick(1);
        din = 16'h0800;
        expect_out("R9", route(din, e_act));
        configure(1'b1);
        expect_out("R9", route(din, e_act));

        // R7: only output 4 changes; the other outputs hold steady across configure
        cur_req = "R7";
        din = 16'h5A3C;
        load_pair(0, 4, 1'b0);
        begin
            logic [N-1:0] before_v;
            #2 before_v = dout;
            configure(1'b1);
            expect_out("R7", (before_v & ~16'h0010) | (route(din, e_act) & 16'h0010));
        end

        // R7 with mixed traffic: model compare every cycle
        for (int k = 0; k < 400; k++) begin
            int r;
            r = int'($urandom % 8);
            din = 16'($urandom);
            if (r < 3)      load_pair(int'($urandom % 16), int'($urandom % 16), ($urandom % 4) == 0);
            else if (r < 5) configure(1'b0);
            else if (r == 5) begin rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1); end
            else            tick(1);
        end

        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule